// File: doc/BRIEF.md
# Bit-Serial Polyphase Branch Filter

This block computes one polyphase branch of a uniform-DFT filter bank as a multiplier-free FIR. Each accepted 8-bit two's-complement sample enters a tap delay line. The block then walks the eight bit-planes of the stored samples, one plane per clock. For each plane, the plane's bits address small tables of precomputed coefficient sums, and a shift-accumulator combines the table outputs. The full-precision 21-bit result is latched and announced with a one-cycle strobe.

The branch taps are picked at elaboration time from a length-32 lowpass prototype with 8-bit coefficients. Three parameters make the selection: the prototype vector, the decimation factor and the branch index. Tap n takes the prototype coefficient at index n*D - m, and any tap whose index falls outside the prototype is zero. A bank instantiates one copy per branch and feeds each copy at the subband rate (for example 8 MHz).

Top module: `pfir_da_branch`

## Requirements
- R1: After reset (asynchronous, active-low `rstN`), `resultValid` is 0, `resultOut` is 0 and every delay-line sample is zero. A reset in the middle of a computation abandons it, so no strobe follows.
- R2: Each result equals the exact sum over n of a(n)·x(k-n). Here a(n) is the prototype coefficient at index n·D − m when that index lies in 0..PROTO_LEN−1, and 0 otherwise. x(k) is the newest accepted sample and older samples start as zero after reset. The prototype is packed with coefficient i in bits [8i+7:8i].
- R3: Inputs are 8-bit two's complement. The most significant bit-plane carries weight −128, so −128 and 127 are both computed exactly in the 21-bit signed result.
- R4: If a sample is accepted at clock edge E0, then `resultValid` is high for exactly one cycle after edge E9, and `resultOut` takes the new value at that same edge.
- R5: `sampleValid` is ignored while a computation is in progress (edges E1..E8 after acceptance). The ignored sample never enters the delay line.
- R6: `resultOut` keeps its value between strobes.
- R7: For a branch index m > 0, tap 0 is zero, so the first result after a reset followed by an impulse is 0.
- R8: A sample presented at edge E9 of the previous computation is accepted, so samples may arrive every 9 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | High for one cycle to offer a new sample |
| sampleIn | input | 8 | Signed input sample |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| resultOut | output | 21 | Signed filter output, held between strobes |

## Verification
A result is due exactly nine edges after the accepting edge. The bench counts falling edges from the cycle in which it raised `sampleValid` and samples the strobe and the value only at the tenth falling edge. At every falling edge in between, it confirms that the strobe is low and the previous result is unchanged. The table walk drives samples at the 9-cycle minimum spacing, so each check of one result falls on the same edge that accepts the next sample. The directed tests use isolated samples, with the same nine-edge count.

// File: rtl/pfir_da_pkg.sv
package pfir_da_pkg;

  localparam int SAMPLE_W  = 8;
  localparam int PLANE_W   = $clog2(SAMPLE_W);
  localparam int GROUP_SZ  = 4;
  localparam int LUT_DEPTH = 1 << GROUP_SZ;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } daState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic               load;    // capture sample, clear accumulator
    logic               accum;   // accumulate current bit-plane
    logic               negate;  // current plane is the sign plane
    logic [PLANE_W-1:0] plane;   // bit-plane index
    logic               finish;  // latch result, raise strobe
  } daStrobe_t;

endpackage

// File: rtl/pfir_da_ctrl.sv
module pfir_da_ctrl
  import pfir_da_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleValid,
  output daStrobe_t strb
);

  localparam logic [PLANE_W-1:0] LAST_PLANE = PLANE_W'(SAMPLE_W - 1);

  daState_t           state;
  logic [PLANE_W-1:0] plane;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      plane <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          plane <= plane + 1'b1;
          if (plane == LAST_PLANE) state <= ST_DONE;
        end
        default: begin
          if (sampleValid) begin
            state <= ST_RUN;
            plane <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.load   = sampleValid && (state != ST_RUN);
    strb.accum  = (state == ST_RUN);
    strb.negate = (state == ST_RUN) && (plane == LAST_PLANE);
    strb.plane  = plane;
    strb.finish = (state == ST_DONE);
  end

  // R4: eight planes, then the finishing cycle
  a_r4_plane_sequence: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && plane == LAST_PLANE) |=> (state == ST_DONE));

  // R4: a finishing cycle is always preceded by the sign plane
  a_r4_done_after_sign: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |-> $past(state == ST_RUN && plane == LAST_PLANE));

endmodule

// File: rtl/pfir_da_lut.sv
module pfir_da_lut
  import pfir_da_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int LUT_W  = COEF_W + $clog2(GROUP_SZ)
) (
  input  logic [GROUP_SZ*COEF_W-1:0] coefs,
  input  logic [GROUP_SZ-1:0]        addr,
  output logic signed [LUT_W-1:0]    partial
);

  logic signed [LUT_W-1:0] entry [LUT_DEPTH];

  // Every entry is the sum of the coefficients whose address bit is set
  always_comb begin
    for (int a = 0; a < LUT_DEPTH; a++) begin
      entry[a] = '0;
      for (int j = 0; j < GROUP_SZ; j++) begin
        if (((a >> j) & 1) != 0)
          entry[a] = entry[a] + LUT_W'($signed(coefs[j*COEF_W +: COEF_W]));
      end
    end
  end

  assign partial = entry[addr];

endmodule

// File: rtl/pfir_da_datapath.sv
module pfir_da_datapath
  import pfir_da_pkg::*;
#(
  parameter int                        PROTO_LEN = 32,
  parameter int                        COEF_W    = 8,
  parameter int                        DECIM     = 2,
  parameter int                        BRANCH    = 0,
  parameter int                        OUT_W     = 21,
  parameter logic [PROTO_LEN*COEF_W-1:0] PROTO   = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  daStrobe_t                  strb,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic                       resultValid,
  output logic signed [OUT_W-1:0]    resultOut
);

  localparam int NTAPS   = (PROTO_LEN + BRANCH + DECIM - 1) / DECIM;
  localparam int NGROUPS = (NTAPS + GROUP_SZ - 1) / GROUP_SZ;
  localparam int NPAD    = NGROUPS * GROUP_SZ;
  localparam int LUT_W   = COEF_W + $clog2(GROUP_SZ);
  localparam int SUM_W   = LUT_W + $clog2(NGROUPS) + 1;

  logic signed [SAMPLE_W-1:0] line [NTAPS];
  logic [NPAD*COEF_W-1:0]     coefVec;
  logic [NPAD-1:0]            planeBits;
  logic signed [LUT_W-1:0]    partial [NGROUPS];
  logic signed [SUM_W-1:0]    treeSum;
  logic signed [OUT_W-1:0]    term;
  logic signed [OUT_W-1:0]    acc;

  // Branch taps: prototype decimated by DECIM, offset by BRANCH
  for (genvar t = 0; t < NPAD; t++) begin : g_tap
    localparam int IDX = t * DECIM - BRANCH;
    if (t < NTAPS && IDX >= 0 && IDX < PROTO_LEN) begin : g_live
      assign coefVec[t*COEF_W +: COEF_W] = PROTO[IDX*COEF_W +: COEF_W];
    end else begin : g_zero
      assign coefVec[t*COEF_W +: COEF_W] = '0;
    end
    if (t < NTAPS) begin : g_bit
      assign planeBits[t] = line[t][strb.plane];
    end else begin : g_nobit
      assign planeBits[t] = 1'b0;
    end
  end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    pfir_da_lut #(
      .COEF_W(COEF_W),
      .LUT_W (LUT_W)
    ) u_lut (
      .coefs  (coefVec[g*GROUP_SZ*COEF_W +: GROUP_SZ*COEF_W]),
      .addr   (planeBits[g*GROUP_SZ +: GROUP_SZ]),
      .partial(partial[g])
    );
  end

  always_comb begin
    treeSum = '0;
    for (int g = 0; g < NGROUPS; g++) treeSum = treeSum + SUM_W'(partial[g]);
  end

  assign term = OUT_W'(treeSum) <<< strb.plane;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NTAPS; i++) line[i] <= '0;
    end else if (strb.load) begin
      line[0] <= sampleIn;
      for (int i = 1; i < NTAPS; i++) line[i] <= line[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            acc <= '0;
    else if (strb.load)   acc <= '0;
    else if (strb.accum)  acc <= strb.negate ? (acc - term) : (acc + term);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut   <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strb.finish;
      if (strb.finish) resultOut <= acc;
    end
  end

  // R3: the subtracting plane is always the most significant one
  a_r3_sign_plane_last: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accum && strb.negate) |-> (strb.plane == PLANE_W'(SAMPLE_W - 1)));

  // R5: no sample enters the delay line while planes are being accumulated
  a_r5_line_frozen: assert property (@(posedge clk) disable iff (!rstN)
    strb.accum |=> (line[0] == $past(line[0])));

  // R6: result held while no finish strobe
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(resultOut));

  // R4: strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

endmodule

// File: rtl/pfir_da_branch.sv
module pfir_da_branch
  import pfir_da_pkg::*;
#(
  parameter int                        PROTO_LEN = 32,
  parameter int                        COEF_W    = 8,
  parameter int                        DECIM     = 2,
  parameter int                        BRANCH    = 0,
  parameter int                        OUT_W     = 21,
  parameter logic [PROTO_LEN*COEF_W-1:0] PROTO   =
    256'h01FEFDFF030706FEF3ECF40E345A767F7F765A340EF4ECF3FE060703FFFDFE01
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic                       resultValid,
  output logic signed [OUT_W-1:0]    resultOut
);

  daStrobe_t strb;

  pfir_da_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .strb       (strb)
  );

  pfir_da_datapath #(
    .PROTO_LEN(PROTO_LEN),
    .COEF_W   (COEF_W),
    .DECIM    (DECIM),
    .BRANCH   (BRANCH),
    .OUT_W    (OUT_W),
    .PROTO    (PROTO)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .sampleIn   (sampleIn),
    .resultValid(resultValid),
    .resultOut  (resultOut)
  );

  // R4: a strobe appears ten sampling edges after the accepting one
  a_r4_latency: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(strb.load, 10));

endmodule

// File: tb/sim_pfir_da_branch.sv
module sim_pfir_da_branch;

  localparam logic [255:0] PROTO_T =
    256'h01FEFDFF030706FEF3ECF40E345A767F7F765A340EF4ECF3FE060703FFFDFE01;
  localparam int HIST = 20;
  localparam int NVEC = 48;
  localparam logic signed [7:0] VEC [NVEC] = '{
    8'sd1, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0,
    8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0,
    -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128,
    -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128,
    -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128,
    8'sd127, 8'sd127, 8'sd127, 8'sd127,
    -8'sd1, 8'sd5, -8'sd77, 8'sd100, 8'sd33, -8'sd128, 8'sd127, 8'sd0
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN;
  logic              sampleValid;
  logic signed [7:0] sampleIn;
  logic              v0, v1;
  logic signed [20:0] r0, r1;

  pfir_da_branch #(.BRANCH(0)) u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .resultValid(v0), .resultOut(r0));

  pfir_da_branch #(.BRANCH(1)) u1 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .resultValid(v1), .resultOut(r1));

  int checks = 0;
  int errors = 0;
  int hist [HIST];
  bit finished = 1'b0;

  function automatic int tapOf(int m, int n);
    int idx;
    idx = n * 2 - m;
    if (idx < 0 || idx > 31) return 0;
    return int'($signed(PROTO_T[idx*8 +: 8]));
  endfunction

  function automatic int model(int m);
    int s;
    s = 0;
    for (int n = 0; n < HIST; n++) s += tapOf(m, n) * hist[n];
    return s;
  endfunction

  task automatic clearHist();
    for (int i = 0; i < HIST; i++) hist[i] = 0;
  endtask

  task automatic pushSample(int x);
    for (int i = HIST - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Isolated sample: drive, then check at the tenth falling edge
  task automatic sendOne(int x, output int e0, output int e1);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn    = 8'(x);
    pushSample(x);
    e0 = model(0);
    e1 = model(1);
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 early strobe", int'(v0), 0);
    @(negedge clk);
    chk("R4 strobe", int'(v0), 1);
    chk("R4 strobe b1", int'(v1), 1);
  endtask

  initial begin
    int e0, e1, p0, p1;
    rstN = 1'b0;
    sampleValid = 1'b0;
    sampleIn = '0;
    clearHist();
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(v0), 0);
    chk("R1 result", int'(r0), 0);
    chk("R1 valid b1", int'(v1), 0);
    chk("R1 result b1", int'(r1), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk at the minimum spacing of 9 cycles (R8)
    p0 = 0;
    p1 = 0;
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleIn    = VEC[k];
      pushSample(int'(VEC[k]));
      e0 = model(0);
      e1 = model(1);
      @(negedge clk);
      sampleValid = 1'b0;
      if (k > 0) begin
        chk("R8 strobe", int'(v0), 1);
        chk((k - 1 >= 18) ? "R3 branch0" : "R2 branch0", int'(r0), p0);
        chk((k - 1 >= 18) ? "R3 branch1" : "R2 branch1", int'(r1), p1);
      end
      repeat (7) begin
        @(negedge clk);
        chk("R4 no strobe", int'(v0), 0);
        if (k > 0) chk("R6 hold", int'(r0), p0);
      end
      p0 = e0;
      p1 = e1;
    end
    @(negedge clk);
    @(negedge clk);
    chk("R8 last strobe", int'(v0), 1);
    chk("R3 last branch0", int'(r0), p0);
    chk("R3 last branch1", int'(r1), p1);

    // Reset in the middle of a computation (R1)
    repeat (2) @(negedge clk);
    sampleValid = 1'b1;
    sampleIn    = 8'sd50;
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    clearHist();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R1 abort strobe", int'(v0), 0);
      chk("R1 abort result", int'(r0), 0);
    end

    // Impulse after reset: branch 1 leads with a zero tap (R7)
    sendOne(1, e0, e1);
    chk("R2 first tap", int'(r0), 1);
    chk("R7 zero lead tap", int'(r1), 0);
    sendOne(0, e0, e1);
    chk("R2 second tap", int'(r0), -3);
    chk("R7 second tap", int'(r1), -2);

    // Samples offered mid-computation are ignored (R5)
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn    = 8'sd10;
    pushSample(10);
    e0 = model(0);
    e1 = model(1);
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (2) @(negedge clk);
    sampleValid = 1'b1;
    sampleIn    = 8'sd99;
    repeat (3) @(negedge clk);
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 no extra strobe", int'(v0), 0);
    @(negedge clk);
    chk("R5 strobe", int'(v0), 1);
    chk("R5 branch0", int'(r0), e0);
    chk("R5 branch1", int'(r1), e1);
    sendOne(-7, e0, e1);
    chk("R5 line clean branch0", int'(r0), e0);
    chk("R5 line clean branch1", int'(r1), e1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule